// File: doc/BRIEF.md
# Always-Running Watchdog with Gated Reset

This block is a watchdog timer whose countdown never stops. Software sets an 8-bit reload value and chooses whether each count is one second or one minute long. A one-second strobe from elsewhere on the chip drives the count. Writing the reload register starts the countdown again from the full value. When the countdown runs out, the counter reloads itself and carries on counting, and a sticky expiry flag is set.

The system reset is gated. A one-cycle reset pulse is driven only when the expiry flag changes from 0 to 1 while the reset-arm bit is set. Clearing the arm bit is the only way to "stop" the watchdog: the timer keeps running, but its expiries no longer reach the reset line. Setting the arm bit after the flag is already set does not cause a reset. A further expiry while the flag is still set does not cause one either.

The host uses a simple register port: a write strobe with address and data, and a separate read address with combinational read data. The current count cannot be read.

Top module: `gated_wdt`

## Requirements
- R1: After reset, the register reads are: reload (address 0) = 0x01, time-base (address 1) = 0x00, arm (address 2) = 0x00, flag (address 3) = 0x00. The `expired_o` and `sys_rst_o` outputs are low.
- R2: A write to the reload register (address 0) reloads the counter with the written value and restarts the time-base divider. The next expiry therefore comes exactly N count units after that write. A write in the same cycle as a count unit wins over that unit.
- R3: With time-base bit 0 set, each `tick_i` pulse is one count unit, so reload value N expires on the Nth tick.
- R4: With time-base bit 0 clear, one count unit is TICKS_PER_MIN (60) tick pulses, so reload value 1 expires on the 60th tick.
- R5: The counter always runs, whatever the arm bit holds. On expiry it reloads from the reload register and expires again every N units.
- R6: Expiry sets bit 0 of the flag register (address 3), which is also output on `expired_o`. Writing 1 to that bit clears it. Writing 0 has no effect. If an expiry and a clear fall in the same cycle, the flag stays set.
- R7: `sys_rst_o` pulses high for exactly one cycle. The pulse comes in the cycle the flag goes from 0 to 1, and only when bit 1 of the arm register (address 2) was set.
- R8: Setting the arm bit while the flag is already set produces no reset pulse. A further expiry while the flag is still set produces none either.
- R9: With the arm bit clear, an expiry sets the flag but produces no reset pulse.
- R10: A reload value of 0 behaves like 1: the counter expires on the next count unit.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| tick_i | input | 1 | One-cycle strobe, once per second |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| expired_o | output | 1 | Sticky expiry flag |
| sys_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The assertions check on every cycle that the reset pulse lasts one cycle and comes only with a rising flag. They also check that an armed rise always produces a pulse, that the flag stays set until it is cleared, that a clear with no expiry pending takes effect, and that a reload write masks any expiry in that cycle. The bench scenarios are needed for everything measured in count units. That covers the exact tick on which expiry falls in each time-base mode, the restart on a reload write, the automatic reload after expiry, and the zero-reload case. The bench also shows that a late arm does not produce a reset.

// File: rtl/gated_wdt_pkg.sv
package gated_wdt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_TBASE  = 2'd1;
  localparam logic [ADDR_W-1:0] A_ARM    = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 2'd3;

  localparam int unsigned TBASE_SEC_BIT = 0;
  localparam int unsigned ARM_BIT       = 1;
  localparam int unsigned FLAG_BIT      = 0;

  localparam logic [DATA_W-1:0] RELOAD_RST = 8'd1;
endpackage

// File: rtl/gated_wdt_rst_sync.sv
module gated_wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gated_wdt_regs.sv
module gated_wdt_regs
  import gated_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              sec_mode_o,
  output logic              arm_o,
  output logic              reload_wr_o,
  output logic              flag_clr_o
);
  logic [DATA_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0] tbase_q, tbase_d;
  logic [DATA_W-1:0] arm_q, arm_d;
  logic              wr_reload, wr_tbase, wr_arm, wr_flag;

  always_comb begin
    wr_reload = wr_en_i && (wr_addr_i == A_RELOAD);
    wr_tbase  = wr_en_i && (wr_addr_i == A_TBASE);
    wr_arm    = wr_en_i && (wr_addr_i == A_ARM);
    wr_flag   = wr_en_i && (wr_addr_i == A_FLAG);
    reload_d  = wr_reload ? wr_data_i : reload_q;
    tbase_d   = wr_tbase  ? wr_data_i : tbase_q;
    arm_d     = wr_arm    ? wr_data_i : arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      tbase_q  <= '0;
      arm_q    <= '0;
    end else begin
      reload_q <= reload_d;
      tbase_q  <= tbase_d;
      arm_q    <= arm_d;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_RELOAD: rd_data_o = reload_q;
      A_TBASE:  rd_data_o = tbase_q;
      A_ARM:    rd_data_o = arm_q;
      default:  rd_data_o = {{(DATA_W-1){1'b0}}, flag_i};
    endcase
  end

  assign reload_o    = reload_q;
  assign sec_mode_o  = tbase_q[TBASE_SEC_BIT];
  assign arm_o       = arm_q[ARM_BIT];
  assign reload_wr_o = wr_reload;
  assign flag_clr_o  = wr_flag && wr_data_i[FLAG_BIT];
endmodule

// File: rtl/gated_wdt_prescale.sv
module gated_wdt_prescale #(
  parameter int unsigned TICKS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic sec_mode_i,
  input  logic restart_i,
  output logic unit_o
);
  localparam int unsigned PW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          at_last;

  always_comb begin
    at_last = (pre_q == LAST);
    unit_o  = tick_i && !restart_i && (sec_mode_i || at_last);
    pre_d   = pre_q;
    if (restart_i || sec_mode_i)  pre_d = '0;
    else if (tick_i)              pre_d = at_last ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/gated_wdt_counter.sv
module gated_wdt_counter
  import gated_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic              expire_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              last_unit;

  always_comb begin
    last_unit = (cnt_q <= DATA_W'(1));
    expire_o  = unit_i && !load_i && last_unit;
    cnt_d     = cnt_q;
    if (load_i)       cnt_d = load_val_i;
    else if (unit_i)  cnt_d = last_unit ? reload_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD_RST;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gated_wdt_event.sv
module gated_wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clr_i,
  input  logic arm_i,
  output logic flag_o,
  output logic rst_pulse_o
);
  logic flag_q, flag_d;
  logic pulse_q, pulse_d;

  always_comb begin
    flag_d  = expire_i || (flag_q && !clr_i);
    pulse_d = expire_i && !flag_q && arm_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign flag_o      = flag_q;
  assign rst_pulse_o = pulse_q;
endmodule

// File: rtl/gated_wdt.sv
module gated_wdt
  import gated_wdt_pkg::*;
#(
  parameter int unsigned TICKS_PER_MIN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              expired_o,
  output logic              sys_rst_o
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] reload;
  logic              sec_mode, arm, reload_wr, flag_clr;
  logic              unit, expire, flag;

  gated_wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gated_wdt_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .flag_i(flag), .rd_data_o(rd_data_o),
    .reload_o(reload), .sec_mode_o(sec_mode), .arm_o(arm),
    .reload_wr_o(reload_wr), .flag_clr_o(flag_clr)
  );

  gated_wdt_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_i),
    .sec_mode_i(sec_mode), .restart_i(reload_wr), .unit_o(unit)
  );

  gated_wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .unit_i(unit),
    .load_i(reload_wr), .load_val_i(wr_data_i), .reload_i(reload),
    .expire_o(expire)
  );

  gated_wdt_event u_evt (
    .clk(clk), .rst_n(rst_sync_n), .expire_i(expire), .clr_i(flag_clr),
    .arm_i(arm), .flag_o(flag), .rst_pulse_o(sys_rst_o)
  );

  assign expired_o = flag;
endmodule

// File: rtl/gated_wdt_chk.sv
module gated_wdt_chk
  import gated_wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_bit0,
  input logic              expire,
  input logic              arm,
  input logic              flag,
  input logic              sys_rst
);
  logic clr_req;
  assign clr_req = wr_en && (wr_addr == A_FLAG) && wr_bit0;

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  assert_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $rose(flag));

  assert_armed_rise_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && expire && arm) |=> sys_rst);

  assert_unarmed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !arm) |=> !sys_rst);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !flag);

  assert_reload_masks_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RELOAD) |-> !expire);
endmodule

bind gated_wdt gated_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
  .wr_bit0(wr_data_i[0]), .expire(expire), .arm(arm), .flag(flag),
  .sys_rst(sys_rst_o)
);

// File: tb/tb_gated_wdt.sv
module tb_gated_wdt;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, wr_en_i;
  logic [1:0] wr_addr_i, rd_addr_i;
  logic [7:0] wr_data_i, rd_data_o;
  logic       expired_o, sys_rst_o;

  int n_run = 0;
  int n_fail = 0;
  int rst_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gated_wdt dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .expired_o(expired_o), .sys_rst_o(sys_rst_o)
  );

  always @(negedge clk) if (sys_rst_o) rst_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [7:0] tb, input logic [7:0] arm, input logic [7:0] pre);
    wr(2'd1, tb); wr(2'd2, arm); wr(2'd0, pre); wr(2'd3, 8'h01);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk(d == 8'h01, "R1 reload", d, 1);
    rd(2'd1, d); chk(d == 8'h00, "R1 tbase", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R1 arm", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R1 flag", d, 0);
    chk(!expired_o && !sys_rst_o, "R1 outputs", {expired_o, sys_rst_o}, 0);
  endtask

  task automatic t_sec_mode;
    logic [7:0] d;
    int r0;
    setup(8'h01, 8'h00, 8'd3);
    r0 = rst_cnt;
    ticks(2); chk(!expired_o, "R3 early", expired_o, 0);
    ticks(1); chk(expired_o, "R3 expiry on tick 3", expired_o, 1);
    rd(2'd3, d); chk(d == 8'h01, "R6 flag reg", d, 1);
    chk(rst_cnt == r0, "R9 no reset when unarmed", rst_cnt - r0, 0);
    wr(2'd3, 8'h01); chk(!expired_o, "R6 clear", expired_o, 0);
    ticks(2); chk(!expired_o, "R5 reload early", expired_o, 0);
    ticks(1); chk(expired_o, "R5 re-expiry", expired_o, 1);
  endtask

  task automatic t_restart;
    setup(8'h01, 8'h00, 8'd4);
    ticks(3);
    wr(2'd0, 8'd4);
    ticks(3); chk(!expired_o, "R2 restarted", expired_o, 0);
    ticks(1); chk(expired_o, "R2 expiry after restart", expired_o, 1);
  endtask

  task automatic t_minute;
    setup(8'h00, 8'h00, 8'd1);
    ticks(59); chk(!expired_o, "R4 tick 59", expired_o, 0);
    ticks(1);  chk(expired_o, "R4 tick 60", expired_o, 1);
  endtask

  task automatic t_armed;
    int r0;
    setup(8'h01, 8'h02, 8'd2);
    r0 = rst_cnt;
    ticks(2);
    chk(expired_o, "R7 flag set", expired_o, 1);
    chk(rst_cnt - r0 == 1, "R7 single pulse", rst_cnt - r0, 1);
    ticks(2);
    chk(rst_cnt - r0 == 1, "R8 second expiry no reset", rst_cnt - r0, 1);
  endtask

  task automatic t_late_arm;
    logic [7:0] d;
    int r0;
    setup(8'h01, 8'h00, 8'd2);
    ticks(2);
    r0 = rst_cnt;
    wr(2'd3, 8'h00);
    rd(2'd3, d); chk(d == 8'h01, "R6 write 0 ignored", d, 1);
    wr(2'd2, 8'h02);
    repeat (5) @(negedge clk);
    chk(rst_cnt == r0, "R8 late arm no reset", rst_cnt - r0, 0);
  endtask

  task automatic t_zero;
    setup(8'h01, 8'h00, 8'd0);
    ticks(1); chk(expired_o, "R10 zero acts as one", expired_o, 1);
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0;
    wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sec_mode();
    t_restart();
    t_minute();
    t_armed();
    t_late_arm();
    t_zero();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog timeout actual=0 expected=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule